// File: doc/BRIEF.md
# Ethernet Transmit Frame Check Sequence Appender

This block sits in the transmit path ahead of the line encoder. It accepts an outgoing MAC frame as a byte stream with valid/ready flow control and start and end markers. The frame holds destination address, source address, length/type, payload and any pad bytes. Each byte passes straight through in the same cycle. While the bytes go by, the block runs a 32-bit cyclic redundancy check over them. After the last byte it sends four more bytes carrying the check value, and moves the end marker onto the last of them.

A compile-time switch turns the appender off. The block is then a plain wire from input to output. The switch defaults to on.

Top module: `eth_fcs_append`

## Requirements
- R1: With insertion on, every accepted input byte leaves on the output in the same cycle with the same value. The output start marker equals the input start marker for that byte, and the output end marker is low for every frame byte.
- R2: The check uses generator 0x04C11DB7 in bit-reflected form, with data bits taken least significant first. The register is preset to all ones on the start byte. The appended value V is the complement of the register after the end byte. The four extra bytes are V[7:0], V[15:8], V[23:16], V[31:24] in that order. For the ASCII bytes "123456789" they are 0x26, 0x39, 0xF4, 0xCB.
- R3: The four check bytes follow the end byte with no idle cycle whenever output ready stays high. Output valid is high throughout, and no byte beyond the four is produced.
- R4: Input ready is low from the cycle after the end byte is accepted until the fourth check byte is accepted.
- R5: The output end marker is high only with the fourth check byte.
- R6: While a check byte waits with output ready low, output valid and output data stay unchanged, and the byte index does not advance.
- R7: A new frame can be accepted on the cycle after the fourth check byte is accepted, and its check value starts again from all ones.
- R8: With insertion off, output valid, data and markers equal the inputs in every cycle, input ready equals output ready, and no bytes are added.
- R9: While the synchronous active-high reset is asserted, output valid and input ready are low. After reset the block is idle and ready for a start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is first of frame |
| out_eof | output | 1 | Output byte is last of frame, including check bytes |

## Verification
On every cycle, the in-module properties check several rules. Input ready must drop after an end byte, and check bytes must start at once. A stalled check byte must be held steady. The state must return to pass-through once the final marked byte leaves. Reset must silence both handshakes. In bypass, the output must never be valid without an input. The values of the check bytes, their order, and the fresh preset between back-to-back frames can only be shown by the bench's reference model. That model computes the check in a different, non-reflected form. The bench runs frames of one, nine and sixty-four bytes under random downstream stalls.

// File: rtl/eth_fcs_append.sv
module eth_fcs_append #(
  parameter bit          INSERT_FCS = 1'b1,
  parameter int          FCS_BYTES  = 4,
  parameter logic [31:0] POLY_REFL  = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  localparam int CRC_W = 8 * FCS_BYTES;
  localparam int IDX_W = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BYTES - 1);

  generate
    if (INSERT_FCS) begin : g_ins
      logic             in_fcs;
      logic [IDX_W-1:0] idx;
      logic [CRC_W-1:0] crc;
      logic [CRC_W-1:0] crc_nxt;
      logic             take_in, take_out;

      function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c, input logic [7:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
          if (r[0] ^ d[b]) r = (r >> 1) ^ POLY_REFL[CRC_W-1:0];
          else             r = r >> 1;
        end
        return r;
      endfunction

      assign take_in  = in_valid && in_ready;
      assign take_out = out_valid && out_ready;
      assign crc_nxt  = step(in_sof ? {CRC_W{1'b1}} : crc, in_data);

      assign in_ready  = !rst && !in_fcs && out_ready;
      assign out_valid = !rst && (in_fcs || in_valid);
      assign out_data  = in_fcs ? ~crc[{idx, 3'b000} +: 8] : in_data;
      assign out_sof   = !in_fcs && in_sof;
      assign out_eof   = in_fcs && (idx == LAST_IDX);

      always_ff @(posedge clk) begin
        if (rst) begin
          in_fcs <= 1'b0;
          idx    <= '0;
          crc    <= '1;
        end else if (take_in) begin
          crc <= crc_nxt;
          if (in_eof) begin
            in_fcs <= 1'b1;
            idx    <= '0;
          end
        end else if (in_fcs && take_out) begin
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) in_fcs <= 1'b0;
        end
      end

      a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (take_in && in_eof) |=> !in_ready);
      a_r3_fcs_follows: assert property (@(posedge clk) disable iff (rst)
        (take_in && in_eof) |=> (out_valid && !out_sof && !out_eof));
      a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (in_fcs && out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));
      a_r7_back_to_pass: assert property (@(posedge clk) disable iff (rst)
        (take_out && out_eof) |=> (in_ready == out_ready));
      always_ff @(posedge clk)
        if (rst) a_r9_quiet: assert (!out_valid && !in_ready);
    end else begin : g_byp
      assign in_ready  = !rst && out_ready;
      assign out_valid = !rst && in_valid;
      assign out_data  = in_data;
      assign out_sof   = in_sof;
      assign out_eof   = in_eof;

      always_ff @(posedge clk)
        a_r8_no_growth: assert (!out_valid || in_valid);
    end
  endgenerate
endmodule

// File: tb/eth_fcs_append_test.sv
module eth_fcs_append_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       in_valid = 0, in_sof = 0, in_eof = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic       in_ready, out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic       b_in_ready, b_out_valid, b_out_sof, b_out_eof;
  logic [7:0] b_out_data;

  eth_fcs_append uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof));

  eth_fcs_append #(.INSERT_FCS(1'b0)) uut_byp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(b_in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .out_valid(b_out_valid), .out_ready(1'b1),
    .out_data(b_out_data), .out_sof(b_out_sof), .out_eof(b_out_eof));

  int checks = 0, failures = 0;
  logic [10:0] expq[$];
  logic [31:0] ref_crc;
  int fcs_left = 0;
  logic [7:0] cap[4];
  int cap_n = 0;
  logic stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_hold = 0, prev_last = 0;
  logic [7:0] prev_data;
  logic [7:0] frame_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction
  function automatic logic [31:0] rev32(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev32[i] = v[31-i];
  endfunction
  function automatic logic [31:0] msb_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {rev8(d), 24'h0};
    for (int i = 0; i < 8; i++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_mode ? lfsr[0] | lfsr[3] : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic in_fcs_now;
      logic [10:0] e;
      logic [31:0] v;
      in_fcs_now = fcs_left > 0;
      chk(b_out_valid == in_valid && b_in_ready == 1'b1, "R8 valid/ready", {b_out_valid, b_in_ready}, {in_valid, 1'b1});
      if (in_valid)
        chk({b_out_eof, b_out_sof, b_out_data} == {in_eof, in_sof, in_data}, "R8 data",
            {b_out_eof, b_out_sof, b_out_data}, {in_eof, in_sof, in_data});
      if (in_fcs_now) begin
        chk(!in_ready, "R4 ready low in FCS", in_ready, 0);
        chk(out_valid, "R3 FCS without gap", out_valid, 1);
      end
      if (prev_hold)
        chk(out_valid && out_data == prev_data, "R6 hold while stalled", out_data, prev_data);
      if (prev_last && in_valid)
        chk(in_ready == out_ready && out_sof == in_sof, "R7 next frame at once", in_ready, out_ready);
      if (in_valid && in_ready) begin
        expq.push_back({2'b00, in_sof, in_data});
        ref_crc = msb_step(in_sof ? 32'hFFFF_FFFF : ref_crc, in_data);
        if (in_eof) begin
          v = ~rev32(ref_crc);
          for (int k = 0; k < 4; k++) expq.push_back({1'b1, k == 3, 1'b0, v[8*k +: 8]});
          fcs_left = 4;
          cap_n = 0;
        end
      end
      prev_last = 0;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(0, "R3 extra byte", out_data, 0);
        else begin
          e = expq.pop_front();
          chk({out_eof, out_sof, out_data} == e[9:0], e[10] ? "R2/R5 FCS byte" : "R1 frame byte",
              {out_eof, out_sof, out_data}, e[9:0]);
          if (e[10]) begin
            cap[cap_n] = out_data;
            cap_n++;
            fcs_left--;
            prev_last = fcs_left == 0;
          end
        end
      end
      prev_hold = in_fcs_now && out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  task automatic send_frame(input bit gaps);
    for (int i = 0; i < frame_q.size(); i++) begin
      in_valid = 1; in_data = frame_q[i];
      in_sof = (i == 0); in_eof = (i == frame_q.size() - 1);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 0; in_sof = 0; in_eof = 0;
      if (gaps && (i % 3 == 0)) begin @(posedge clk); #1; end
    end
  endtask

  task automatic fill(input int n, input int seed);
    frame_q.delete();
    for (int i = 0; i < n; i++) frame_q.push_back(8'((seed * 37 + i * 13) ^ (i >> 2)));
  endtask

  task automatic drain;
    int t = 0;
    while ((expq.size() != 0) && t < 2000) begin @(posedge clk); t++; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0 && !out_valid, "R3 frame complete", expq.size(), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    chk(0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    in_valid = 1; in_sof = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !in_ready, "R9 reset quiet", {out_valid, in_ready}, 0);
    @(posedge clk); #1;
    rst = 0; in_valid = 0; in_sof = 0;
    @(negedge clk);
    chk(in_ready && !out_valid, "R9 idle after reset", {in_ready, out_valid}, 2'b10);

    frame_q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    @(posedge clk); #1;
    send_frame(0);
    drain();
    chk({cap[0], cap[1], cap[2], cap[3]} == 32'h2639F4CB, "R2 known vector",
        {cap[0], cap[1], cap[2], cap[3]}, 32'h2639F4CB);

    @(posedge clk); #1;
    fill(1, 5); send_frame(0); drain();
    @(posedge clk); #1;
    fill(64, 9); send_frame(1); drain();

    @(posedge clk); #1;
    for (int f = 0; f < 4; f++) begin fill(3 + f * 7, f); send_frame(0); end
    drain();

    stall_mode = 1;
    @(posedge clk); #1;
    for (int f = 0; f < 8; f++) begin fill(1 + f * 5, 40 + f); send_frame(f[0]); end
    drain();
    stall_mode = 0;
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule